// File: doc/BRIEF.md
# Quadword Access Splitting Sequencer

This block sits between instruction decode and a 64-bit data-cache port. It takes one decoded 128-bit load or store and turns it into two consecutive 64-bit accesses. The request carries the effective address, the even register number of the pair, the base and index register numbers, and flags for load versus store, reservation (load-reserve or store-conditional), prefixed encoding, big-endian mode and 32-bit addressing.

For each half the block works out the address, which register of the pair goes with it, and whether the two halves form one aligned atomic pair. It also screens the request before issue. Register-pair forms the architecture forbids are flagged as illegal. Unaligned accesses that could corrupt the base register, or that break reservation rules, are flagged as alignment traps. A screened-out request produces one error beat and never reaches the second half.

Both sides use valid/ready handshakes. The sequencer holds one request at a time. It accepts the next request only after the final beat of the current one has been taken.

Top module: `qw_split_seq`

## Requirements
- R1: `req_ready` is high only while no request is in flight. It drops at the edge that accepts a request and rises again at the edge that takes that request's final beat.
- R2: A legal request produces exactly two beats. The first has `acc_half`=0 and the effective address. The second has `acc_half`=1 and the effective address plus 8.
- R3: When the request is non-prefixed and little-endian (`req_big_endian`=0), the first beat carries register RT|1 and the second carries RT. In every other case the first beat carries RT and the second carries RT|1.
- R4: When address bits [3:0] are all zero, both beats have `acc_atomic`=1 and only the second beat has `acc_last`=1. Otherwise `acc_atomic` and `acc_last` stay 0 on both beats.
- R5: A reservation request (`req_reserve`=1) whose address bits [3:0] are not all zero raises `acc_align_trap`.
- R6: A non-prefixed little-endian load with non-zero address bits [3:0] raises `acc_align_trap`. Non-reservation stores, prefixed loads and big-endian loads with the same address do not trap.
- R7: A request whose register number has bit 0 set raises `acc_illegal`.
- R8: A load with RA equal to RT raises `acc_illegal`. A reservation load with RB equal to RT also raises it. A store with RA equal to RS does not, and neither does a plain load with RB equal to RT.
- R9: A request that raises a trap or an illegal-form flag produces a single beat: `acc_half`=0, no atomic or last flag, and the first-half address and register. No second beat follows.
- R10: With `req_mode32`=1, bits [63:32] of every issued address are zero. Bits [31:0] wrap modulo 2^32 when 8 is added.
- R11: While `acc_valid` is high and `acc_ready` is low, every beat output holds its value.
- R12: After reset, `req_ready` is 1 and `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_ea | input | 64 | Effective address of the quadword |
| req_rt | input | 5 | Target/source register pair number |
| req_ra | input | 5 | Base register number |
| req_rb | input | 5 | Index register number |
| req_load | input | 1 | 1 = load, 0 = store |
| req_reserve | input | 1 | Load-reserve or store-conditional |
| req_prefixed | input | 1 | Prefixed encoding |
| req_big_endian | input | 1 | Big-endian mode |
| req_mode32 | input | 1 | 32-bit addressing mode |
| acc_valid | output | 1 | Beat offered to cache port |
| acc_ready | input | 1 | Cache port takes the beat |
| acc_addr | output | 64 | Beat address |
| acc_reg | output | 5 | Register number for this beat |
| acc_load | output | 1 | Beat is a load |
| acc_reserve | output | 1 | Beat belongs to a reservation access |
| acc_half | output | 1 | 0 = first half, 1 = second half |
| acc_atomic | output | 1 | Beat is part of an aligned atomic pair |
| acc_last | output | 1 | Final beat of an atomic pair |
| acc_align_trap | output | 1 | Error beat: alignment trap |
| acc_illegal | output | 1 | Error beat: illegal instruction form |

## Verification
Aligned requests are run across every combination of endianness and prefix. Comparing them shows whether the register order depends on both inputs or only on one.

Misaligned addresses (low nibble 8, and non-zero low bits) are run with loads, stores and reservation accesses, prefixed and not. These separate the load-only trap rule from the reservation trap rule, and show that bit 3 alone breaks atomicity.

Pairs that differ only in which register numbers match (RA or RB against RT, load against store) isolate each illegal-form term. A wrapping address in 32-bit mode, together with random back-pressure on the cache port, shows that the address masking and the hold-while-stalled rule both work.

// File: rtl/qw_split_pkg.sv
// Package: shared types for the quadword splitting sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package qw_split_pkg;

    // Sequencer phase: idle, presenting first half, presenting second half
    typedef enum logic [1:0] {
        QS_IDLE   = 2'd0,
        QS_FIRST  = 2'd1,
        QS_SECOND = 2'd2
    } qs_state_e;

endpackage

// File: rtl/qw_form_check.sv
// Module: qw_form_check
// Classifies a captured quadword request: illegal register form,
// alignment trap, aligned atomic pair, and register-pair order.
// Assumes: ea_low holds the low OFFB+1 address bits of the first half.
module qw_form_check #(
    parameter int RW   = 5,
    parameter int OFFB = 3
) (
    input  logic [OFFB:0]   ea_low,
    input  logic [RW-1:0]   rt,
    input  logic [RW-1:0]   ra,
    input  logic [RW-1:0]   rb,
    input  logic            is_load,
    input  logic            reserve,
    input  logic            prefixed,
    input  logic            big_endian,
    output logic            illegal,
    output logic            align_trap,
    output logic            aligned_pair,
    output logic            swap_order
);
    logic misaligned;

    // Purpose: derive alignment, order and fault classification
    always_comb begin
        misaligned   = |ea_low[OFFB-1:0];
        aligned_pair = !misaligned && !ea_low[OFFB];
        swap_order   = !big_endian && !prefixed;
        illegal      = rt[0]
                     || (is_load && (ra == rt))
                     || (is_load && reserve && (rb == rt));
        align_trap   = !aligned_pair
                     && (reserve || (is_load && swap_order));
    end

endmodule

// File: rtl/qw_half_addr.sv
// Module: qw_half_addr
// Forms the address of one half: first half uses the base address,
// second half adds one doubleword; 32-bit mode clears the upper word.
// Assumes: HALF_BYTES is a power of two and AW > OFFB.
module qw_half_addr #(
    parameter int AW         = 64,
    parameter int HALF_BYTES = 8
) (
    input  logic [AW-1:0] ea,
    input  logic          second,
    input  logic          mode32,
    output logic [AW-1:0] addr
);
    localparam int OFFB = $clog2(HALF_BYTES);

    logic [AW-1:0] raw;

    // Purpose: step to next doubleword for the second half
    always_comb begin
        raw = {ea[AW-1:OFFB] + (AW-OFFB)'(second), ea[OFFB-1:0]};
    end

    generate
        if (AW > 32) begin : g_mask
            // Purpose: zero the upper address bits in 32-bit mode
            always_comb begin
                addr = raw;
                if (mode32) addr[AW-1:32] = '0;
            end
        end else begin : g_nomask
            // Purpose: narrow address space needs no masking
            always_comb addr = raw;
            logic unused_m32;
            assign unused_m32 = mode32;
        end
    endgenerate

endmodule

// File: rtl/qw_split_seq.sv
// Module: qw_split_seq (top)
// Accepts one 128-bit load/store request and issues it as two 64-bit
// beats, or as a single error beat when the form is illegal or the
// alignment rules require a trap.
// Assumes: one request in flight; downstream obeys valid/ready.
module qw_split_seq
    import qw_split_pkg::*;
#(
    parameter int AW         = 64,
    parameter int RW         = 5,
    parameter int HALF_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_ea,
    input  logic [RW-1:0] req_rt,
    input  logic [RW-1:0] req_ra,
    input  logic [RW-1:0] req_rb,
    input  logic          req_load,
    input  logic          req_reserve,
    input  logic          req_prefixed,
    input  logic          req_big_endian,
    input  logic          req_mode32,
    output logic          acc_valid,
    input  logic          acc_ready,
    output logic [AW-1:0] acc_addr,
    output logic [RW-1:0] acc_reg,
    output logic          acc_load,
    output logic          acc_reserve,
    output logic          acc_half,
    output logic          acc_atomic,
    output logic          acc_last,
    output logic          acc_align_trap,
    output logic          acc_illegal
);
    localparam int OFFB = $clog2(HALF_BYTES);

    qs_state_e     state_q;
    logic [AW-1:0] ea_q;
    logic [RW-1:0] rt_q, ra_q, rb_q;
    logic          load_q, rsv_q, pfx_q, be_q, m32_q;

    logic          f_illegal, f_trap, f_pair, f_swap, f_err;
    logic          second;

    // Purpose: phase sequencing across the two handshakes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= QS_IDLE;
        end else begin
            case (state_q)
                QS_IDLE:   if (req_valid) state_q <= QS_FIRST;
                QS_FIRST:  if (acc_ready) state_q <= f_err ? QS_IDLE : QS_SECOND;
                QS_SECOND: if (acc_ready) state_q <= QS_IDLE;
                default:   state_q <= QS_IDLE;
            endcase
        end
    end

    // Purpose: capture the request fields at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q   <= '0;
            rt_q   <= '0;
            ra_q   <= '0;
            rb_q   <= '0;
            load_q <= 1'b0;
            rsv_q  <= 1'b0;
            pfx_q  <= 1'b0;
            be_q   <= 1'b0;
            m32_q  <= 1'b0;
        end else if (state_q == QS_IDLE && req_valid) begin
            ea_q   <= req_ea;
            rt_q   <= req_rt;
            ra_q   <= req_ra;
            rb_q   <= req_rb;
            load_q <= req_load;
            rsv_q  <= req_reserve;
            pfx_q  <= req_prefixed;
            be_q   <= req_big_endian;
            m32_q  <= req_mode32;
        end
    end

    qw_form_check #(.RW(RW), .OFFB(OFFB)) u_check (
        .ea_low       (ea_q[OFFB:0]),
        .rt           (rt_q),
        .ra           (ra_q),
        .rb           (rb_q),
        .is_load      (load_q),
        .reserve      (rsv_q),
        .prefixed     (pfx_q),
        .big_endian   (be_q),
        .illegal      (f_illegal),
        .align_trap   (f_trap),
        .aligned_pair (f_pair),
        .swap_order   (f_swap)
    );

    assign second = (state_q == QS_SECOND);

    qw_half_addr #(.AW(AW), .HALF_BYTES(HALF_BYTES)) u_addr (
        .ea     (ea_q),
        .second (second),
        .mode32 (m32_q),
        .addr   (acc_addr)
    );

    // Purpose: drive handshake and per-beat attributes
    always_comb begin
        f_err          = f_illegal || f_trap;
        req_ready      = (state_q == QS_IDLE);
        acc_valid      = (state_q != QS_IDLE);
        acc_half       = second;
        acc_reg        = {rt_q[RW-1:1], rt_q[0] | (second ^ f_swap)};
        acc_load       = load_q;
        acc_reserve    = rsv_q;
        acc_atomic     = acc_valid && f_pair && !f_err;
        acc_last       = acc_atomic && second;
        acc_align_trap = (state_q == QS_FIRST) && f_trap;
        acc_illegal    = (state_q == QS_FIRST) && f_illegal;
    end

endmodule

// File: rtl/qw_split_seq_chk.sv
// Module: qw_split_seq_chk
// Temporal checks on the sequencer's ports, bound into qw_split_seq.
// Assumes: synchronous active-low reset on rst_n.
module qw_split_seq_chk #(
    parameter int AW = 64,
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          acc_valid,
    input logic          acc_ready,
    input logic [AW-1:0] acc_addr,
    input logic [RW-1:0] acc_reg,
    input logic          acc_half,
    input logic          acc_atomic,
    input logic          acc_last,
    input logic          acc_align_trap,
    input logic          acc_illegal
);
    logic started;

    // Purpose: mark cycles that have a sampled past after reset
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> !req_ready);

    a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (acc_valid && !acc_half));

    a_r2_second_plus8: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (acc_valid && acc_ready && !acc_half && !acc_align_trap && !acc_illegal)
        |=> (acc_valid && acc_half && acc_addr[31:0] == $past(acc_addr[31:0]) + 32'd8));

    a_r4_atomic_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        acc_atomic |-> (acc_addr[2:0] == 3'd0 && acc_addr[3] == acc_half));

    a_r4_last_only_second: assert property (@(posedge clk) disable iff (!rst_n)
        acc_last |-> (acc_atomic && acc_half));

    a_r9_error_single: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && (acc_align_trap || acc_illegal)) |=> !acc_valid);

    a_r9_error_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_align_trap || acc_illegal) |-> (acc_valid && !acc_half && !acc_atomic));

    a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (acc_valid && !acc_ready)
        |=> (acc_valid && $stable(acc_addr) && $stable(acc_reg) && $stable(acc_half)));

endmodule

bind qw_split_seq qw_split_seq_chk #(.AW(AW), .RW(RW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .acc_valid      (acc_valid),
    .acc_ready      (acc_ready),
    .acc_addr       (acc_addr),
    .acc_reg        (acc_reg),
    .acc_half       (acc_half),
    .acc_atomic     (acc_atomic),
    .acc_last       (acc_last),
    .acc_align_trap (acc_align_trap),
    .acc_illegal    (acc_illegal)
);

// File: tb/qw_split_seq_bench.sv
`timescale 1ns/1ps
module qw_split_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ea = '0;
    logic [4:0]  req_rt = '0, req_ra = '0, req_rb = '0;
    logic        req_load = 1'b0, req_reserve = 1'b0, req_prefixed = 1'b0;
    logic        req_big_endian = 1'b0, req_mode32 = 1'b0;
    logic        acc_valid;
    logic        acc_ready = 1'b1;
    logic [63:0] acc_addr;
    logic [4:0]  acc_reg;
    logic        acc_load, acc_reserve, acc_half, acc_atomic, acc_last;
    logic        acc_align_trap, acc_illegal;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit bp_en  = 1'b0;
    bit done   = 1'b0;

    typedef struct {
        logic [63:0] addr;
        logic [4:0]  rg;
        logic        ld, rsv, half, atom, last, trap, ill;
        string       tag;
    } beat_t;

    beat_t exp_q[$];

    always #2 clk = ~clk;

    qw_split_seq u_qw_split_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_ea(req_ea), .req_rt(req_rt), .req_ra(req_ra), .req_rb(req_rb),
        .req_load(req_load), .req_reserve(req_reserve), .req_prefixed(req_prefixed),
        .req_big_endian(req_big_endian), .req_mode32(req_mode32),
        .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_addr(acc_addr), .acc_reg(acc_reg), .acc_load(acc_load),
        .acc_reserve(acc_reserve), .acc_half(acc_half), .acc_atomic(acc_atomic),
        .acc_last(acc_last), .acc_align_trap(acc_align_trap), .acc_illegal(acc_illegal)
    );

    task automatic check(input bit ok, input string tag, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Driver: build expected beats from the requirements, then offer request
    task automatic send(input logic [63:0] ea, input logic [4:0] rt, ra, rb,
                        input logic ld, rsv, pfx, be, m32, input string tag);
        beat_t b0, b1;
        logic swap, ill, trap, pair;
        logic [63:0] e1;
        swap = !be && !pfx;                                   // R3
        ill  = rt[0] || (ld && ra == rt) || (ld && rsv && rb == rt);   // R7 R8
        pair = (ea[3:0] == 4'd0);                             // R4
        trap = !pair && (rsv || (ld && swap));                // R5 R6
        e1   = ea + 64'd8;                                    // R2
        b0.addr = m32 ? {32'd0, ea[31:0]} : ea;               // R10
        b1.addr = m32 ? {32'd0, e1[31:0]} : e1;
        b0.rg = swap ? (rt | 5'd1) : rt;
        b1.rg = swap ? rt : (rt | 5'd1);
        b0.ld = ld; b1.ld = ld; b0.rsv = rsv; b1.rsv = rsv;
        b0.half = 1'b0; b1.half = 1'b1;
        b0.tag = tag; b1.tag = tag;
        if (ill || trap) begin                                // R9
            b0.atom = 1'b0; b0.last = 1'b0; b0.trap = trap; b0.ill = ill;
            exp_q.push_back(b0);
        end else begin
            b0.atom = pair; b0.last = 1'b0; b0.trap = 1'b0; b0.ill = 1'b0;
            b1.atom = pair; b1.last = pair; b1.trap = 1'b0; b1.ill = 1'b0;
            exp_q.push_back(b0);
            exp_q.push_back(b1);
        end
        @(negedge clk);
        req_ea = ea; req_rt = rt; req_ra = ra; req_rb = rb;
        req_load = ld; req_reserve = rsv; req_prefixed = pfx;
        req_big_endian = be; req_mode32 = m32; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: set back-pressure, then compare each handshaken beat
    always @(negedge clk) begin
        cyc++;
        acc_ready = bp_en ? ((cyc[0] ^ cyc[2]) | cyc[3]) : 1'b1;
        if (rst_n && acc_valid && acc_ready) begin
            beat_t e;
            check(!req_ready, "R1", $sformatf("req_ready=%0d while beat pending exp 0", req_ready));
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", $sformatf("unexpected beat addr=%h half=%0d", acc_addr, acc_half));
            end else begin
                e = exp_q.pop_front();
                check({acc_addr, acc_reg, acc_load, acc_reserve, acc_half, acc_atomic,
                       acc_last, acc_align_trap, acc_illegal} ==
                      {e.addr, e.rg, e.ld, e.rsv, e.half, e.atom, e.last, e.trap, e.ill},
                      e.tag,
                      $sformatf("act addr=%h reg=%0d ld=%0d rsv=%0d h=%0d at=%0d la=%0d tr=%0d il=%0d exp addr=%h reg=%0d ld=%0d rsv=%0d h=%0d at=%0d la=%0d tr=%0d il=%0d",
                                acc_addr, acc_reg, acc_load, acc_reserve, acc_half, acc_atomic,
                                acc_last, acc_align_trap, acc_illegal,
                                e.addr, e.rg, e.ld, e.rsv, e.half, e.atom, e.last, e.trap, e.ill));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, act hung exp done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic drain();
        int n;
        n = 0;
        while ((exp_q.size() != 0 || acc_valid) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && acc_valid == 1'b0, "R12",
              $sformatf("act ready=%0d valid=%0d exp 1 0", req_ready, acc_valid));
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && acc_valid == 1'b0, "R12",
              $sformatf("after release ready=%0d valid=%0d exp 1 0", req_ready, acc_valid));

        // R2 R3 R4: aligned, all endian/prefix combinations
        send(64'h1000, 5'd4, 5'd1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3_be_store");
        send(64'h1010, 5'd4, 5'd1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3_le_store");
        send(64'h1020, 5'd6, 5'd1, 5'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3_le_pfx_load");
        send(64'h1030, 5'd8, 5'd1, 5'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4_be_pfx_load");
        // R4 R6: bit 3 set or low bits set
        send(64'h2008, 5'd10, 5'd1, 5'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6_le_load_trap");
        send(64'h2008, 5'd10, 5'd1, 5'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4_be_load_nonatomic");
        send(64'h3003, 5'd12, 5'd1, 5'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6_pfx_load_notrap");
        send(64'h3005, 5'd12, 5'd1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6_le_store_notrap");
        // R5: reservation alignment
        send(64'h4000, 5'd14, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5_rsv_aligned");
        send(64'h4004, 5'd14, 5'd1, 5'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R5_rsv_store_trap");
        send(64'h4008, 5'd14, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5_rsv_load_trap");
        // R7 R8 R9: illegal forms
        send(64'h5000, 5'd7, 5'd1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7_odd_rs");
        send(64'h5000, 5'd16, 5'd16, 5'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8_ra_eq_rt");
        send(64'h5000, 5'd18, 5'd1, 5'd18, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R8_rb_eq_rt_rsv");
        send(64'h5000, 5'd18, 5'd18, 5'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8_store_ra_eq_rs_ok");
        send(64'h5000, 5'd20, 5'd1, 5'd20, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8_load_rb_eq_rt_ok");
        // R10: 32-bit mode masking and wrap
        send(64'hFFFF_FFFF_FFFF_FFF8, 5'd22, 5'd1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R10_wrap");
        send(64'hABCD_0000_0000_1230, 5'd22, 5'd1, 5'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R10_mask");
        drain();

        // R11: same kinds of traffic under back-pressure
        bp_en = 1'b1;
        send(64'h6000, 5'd24, 5'd1, 5'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11_bp_le_load");
        send(64'h6018, 5'd26, 5'd1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R11_bp_be_store");
        send(64'h6001, 5'd26, 5'd1, 5'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R11_bp_trap");
        send(64'h6020, 5'd3, 5'd1, 5'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R11_bp_illegal");
        send(64'h6030, 5'd28, 5'd1, 5'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R11_bp_pfx");
        drain();
        bp_en = 1'b0;

        check(exp_q.size() == 0, "R2",
              $sformatf("missing beats act %0d exp 0", exp_q.size()));
        check(req_ready == 1'b1 && acc_valid == 1'b0, "R1",
              $sformatf("idle at end act ready=%0d valid=%0d exp 1 0", req_ready, acc_valid));
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule